// File: doc/BRIEF.md
# TMDS Symbol Serializer with Literal Word Mode

This block turns a stream of 32-bit words, one per pixel period, into serial bits for three TMDS data channels and a TMDS clock channel. Each pixel period is ten system clocks long, so the system clock has to run at ten times the pixel rate. A word with bit 1 clear carries 8-bit red, green and blue values. Each byte goes through a DVI 8b/10b encoder with its own running disparity. A word with bit 1 set carries three 10-bit symbols that were encoded upstream, such as data-island or control symbols. Those symbols are sent exactly as given and do not pass through the encoder.

A free-running bit counter steps through slots 0 to 9 and then wraps, so the clock channel always shows a 10-bit five-high, five-low pattern. Near the end of each period the block raises a one-cycle request. An upstream source that answers with `word_valid_i` in that same cycle gets seamless back-to-back symbols. A word loaded at any other time restarts the period at slot 0. When no word arrives, the block keeps sending the symbols it last loaded.

Top module: `tmds_serializer`

## Requirements
- R1: While `rst_ni` is low and after its release, the three data channels output 0, the per-channel disparities are 0, the bit counter is at slot 0, `word_req_o` is low, and `pins_o` equals 8'h40.
- R2: Without loads, the bit counter steps 0,1,...,9,0 on every clock. The clock channel (`pins_o[6]`) is 1 in slots 0 to 4 and 0 in slots 5 to 9, giving a period of exactly 10 clocks.
- R3: In slot n, each data channel drives bit n of its current 10-bit symbol, so symbols go out LSB first. Channel 0 (blue) is on `pins_o[0]`, channel 1 (green) is on `pins_o[2]`, and channel 2 (red) is on `pins_o[4]`.
- R4: A word sampled with `word_valid_i` high on a clock edge takes effect on that edge: the next cycle shows slot 0 of the new symbols, whatever slot was active before.
- R5: `word_req_o` is high only during slot 9, which is one cycle in every ten while no load arrives. A word presented during that cycle continues the 10-clock cadence without a gap.
- R6: While no word is loaded, every later period repeats the last symbols unchanged.
- R7: When bit 1 of the word is 1, bits 31:22 are sent on channel 2, bits 21:12 on channel 1 and bits 11:2 on channel 0, without encoding. The disparity of every channel is left unchanged.
- R8: When bit 1 of the word is 0, the red byte (bits 31:24), the green byte (bits 23:16) and the blue byte (bits 15:8) are each encoded with the DVI 8b/10b transition-minimising and DC-balancing rules. Each channel uses and updates its own running disparity. Bits 7:0 have no effect in this mode.
- R9: The odd bits of `pins_o` (the negative-polarity positions) are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, ten times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 32 | Pixel or literal word |
| word_valid_i | input | 1 | Loads `word_i` on this clock edge |
| word_req_o | output | 1 | High during the last bit slot of a period |
| pins_o | output | 8 | Even bits: channel 0, 1, 2 and clock (positive polarity); odd bits: 0 |

## Verification
A load takes effect on the clock edge that samples `word_valid_i`, and slot 0 of the new symbols is visible during the next cycle. The bench therefore drives inputs on falling edges and compares `pins_o` on each later falling edge. It tracks the expected slot itself: the slot advances by one per edge, wraps after 9, and goes back to 0 after a load edge. Because `word_req_o` is a decode of the current slot, it is checked in the same cycle as the pins. Seamless loads are issued in the cycle where the bench expects slot 9, and off-cadence loads restart the expected slot in the cycle that follows the load.

// File: rtl/tmds_pkg.sv
package tmds_pkg;
  localparam int DISP_W = 6;
  typedef logic signed [DISP_W-1:0] disp_t;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/tmds_enc.sv
module tmds_enc
  import tmds_pkg::*;
(
  input  logic [7:0] data_i,
  input  disp_t      disp_i,
  output logic [9:0] sym_o,
  output disp_t      disp_o
);
  logic [3:0] n1_d, n1_q;
  logic       use_xnor;
  logic [8:0] qm;
  disp_t      bal;
  disp_t      two_if_q8;

  always_comb begin
    n1_d     = ones8(data_i);
    use_xnor = (n1_d > 4'd4) || ((n1_d == 4'd4) && !data_i[0]);
    qm[0]    = data_i[0];
    for (int i = 1; i < 8; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ data_i[i]) : (qm[i-1] ^ data_i[i]);
    qm[8]    = ~use_xnor;
    n1_q     = ones8(qm[7:0]);
    // ones minus zeros of the 8 coded bits
    bal       = disp_t'(2) * disp_t'({1'b0, n1_q}) - disp_t'(8);
    two_if_q8 = qm[8] ? disp_t'(2) : disp_t'(0);

    if ((disp_i == 0) || (bal == 0)) begin
      sym_o  = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      disp_o = qm[8] ? (disp_i + bal) : (disp_i - bal);
    end else if (((disp_i > 0) && (bal > 0)) || ((disp_i < 0) && (bal < 0))) begin
      sym_o  = {1'b1, qm[8], ~qm[7:0]};
      disp_o = disp_i + two_if_q8 - bal;
    end else begin
      sym_o  = {1'b0, qm[8], qm[7:0]};
      disp_o = disp_i - (disp_t'(2) - two_if_q8) + bal;
    end
  end
endmodule

// File: rtl/tmds_bit_ctr.sv
module tmds_bit_ctr #(
  parameter int SYM_W = 10,
  localparam int CNT_W = $clog2(SYM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("cnt range"); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0)) else $error("cnt wrap"); // R2
  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0)) else $error("load restart"); // R4
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o) else $error("req width"); // R5
endmodule

// File: rtl/tmds_chan.sv
module tmds_chan
  import tmds_pkg::*;
#(
  parameter int SYM_W = 10,
  localparam int CNT_W = $clog2(SYM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             lit_i,
  input  logic [SYM_W-1:0] lit_sym_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] slot_i,
  output logic             bit_o
);
  logic [SYM_W-1:0] sym_q;
  disp_t            disp_q;
  logic [9:0]       enc_sym;
  disp_t            enc_disp;

  tmds_enc u_enc (
    .data_i (byte_i),
    .disp_i (disp_q),
    .sym_o  (enc_sym),
    .disp_o (enc_disp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= '0;
      disp_q <= '0;
    end else if (load_i) begin
      if (lit_i) begin
        sym_q <= lit_sym_i;
      end else begin
        sym_q  <= SYM_W'(enc_sym);
        disp_q <= enc_disp;
      end
    end
  end

  assign bit_o = sym_q[slot_i];

  AST_SYM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sym_q)) else $error("symbol hold"); // R6
  AST_LIT_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && lit_i) |=> $stable(disp_q)) else $error("literal disparity"); // R7
  AST_LIT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && lit_i) |=> (sym_q == $past(lit_sym_i))) else $error("literal load"); // R7
endmodule

// File: rtl/tmds_serializer.sv
module tmds_serializer #(
  parameter int WORD_W  = 32,
  parameter int SYM_W   = 10,
  parameter int CH_N    = 3,
  parameter int PIN_W   = 8,
  parameter int LIT_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_req_o,
  output logic [PIN_W-1:0]  pins_o
);
  localparam int CNT_W   = $clog2(SYM_W);
  localparam int CLK_HI  = SYM_W / 2;
  localparam int CLK_PIN = 2 * CH_N;
  localparam int LIT_LSB = LIT_BIT + 1;

  logic [CNT_W-1:0] slot;
  logic [CH_N-1:0]  ch_bit;
  logic             is_lit;
  logic             clk_bit;

  assign is_lit = word_i[LIT_BIT];

  tmds_bit_ctr #(.SYM_W(SYM_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (word_valid_i),
    .cnt_o  (slot),
    .last_o (word_req_o)
  );

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    tmds_chan #(.SYM_W(SYM_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (word_valid_i),
      .lit_i     (is_lit),
      .lit_sym_i (word_i[LIT_LSB + k*SYM_W +: SYM_W]),
      .byte_i    (word_i[WORD_W - 8*(CH_N-k) +: 8]),
      .slot_i    (slot),
      .bit_o     (ch_bit[k])
    );
  end

  assign clk_bit = (slot < CNT_W'(CLK_HI));

  always_comb begin
    pins_o = '0;
    for (int k = 0; k < CH_N; k++) pins_o[2*k] = ch_bit[k];
    pins_o[CLK_PIN] = clk_bit;
  end

  AST_CLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot == CNT_W'(CLK_HI-1)) && !word_valid_i) |=> $fell(pins_o[CLK_PIN]))
    else $error("clock fall"); // R2
  AST_CLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_req_o && !word_valid_i) |=> $rose(pins_o[CLK_PIN]))
    else $error("clock rise"); // R2
  AST_NEG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i |=> (pins_o[1] == 1'b0)) else $error("neg pin"); // R9
endmodule

// File: tb/tmds_serializer_tb.sv
module tmds_serializer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_req_o;
  logic [7:0]  pins_o;

  tmds_serializer u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_req_o   (word_req_o),
    .pins_o       (pins_o)
  );

  always #2ns clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  int cur_slot = 0;
  logic [9:0] exp_sym [3];
  int exp_disp [3];
  bit done = 0;

  function automatic int pop8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [9:0] enc_byte(input logic [7:0] d, input int din, output int dout);
    logic [8:0] m;
    logic [9:0] s;
    int ones, zeros;
    bit x;
    x = (pop8(d) > 4) || (pop8(d) == 4 && d[0] == 1'b0);
    m[0] = d[0];
    for (int i = 1; i < 8; i++) m[i] = x ? ~(m[i-1] ^ d[i]) : (m[i-1] ^ d[i]);
    m[8] = ~x;
    ones = pop8(m[7:0]);
    zeros = 8 - ones;
    if (din == 0 || ones == zeros) begin
      s = {~m[8], m[8], m[8] ? m[7:0] : ~m[7:0]};
      dout = m[8] ? din + ones - zeros : din + zeros - ones;
    end else if ((din > 0 && ones > zeros) || (din < 0 && zeros > ones)) begin
      s = {1'b1, m[8], ~m[7:0]};
      dout = din + (m[8] ? 2 : 0) + zeros - ones;
    end else begin
      s = {1'b0, m[8], m[7:0]};
      dout = din - (m[8] ? 0 : 2) + ones - zeros;
    end
    return s;
  endfunction

  function automatic logic [7:0] exp_pins(input int slot);
    logic [7:0] p = '0;
    p[0] = exp_sym[0][slot];
    p[2] = exp_sym[1][slot];
    p[4] = exp_sym[2][slot];
    p[6] = (slot < 5);
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s slot %0d: got %h expected %h", tag, cur_slot, got, exp);
    end
  endtask

  task automatic check_now(input string tag);
    check(tag, {24'b0, pins_o}, {24'b0, exp_pins(cur_slot)});
    check("R5", {31'b0, word_req_o}, {31'b0, cur_slot == 9});
    check("R9", {28'b0, pins_o[7], pins_o[5], pins_o[3], pins_o[1]}, 32'd0);
  endtask

  task automatic step();
    bit ld = word_valid_i;
    @(negedge clk_i);
    cur_slot = ld ? 0 : (cur_slot == 9 ? 0 : cur_slot + 1);
  endtask

  task automatic watch(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      check_now(tag);
      step();
    end
  endtask

  task automatic load(input logic [31:0] w);
    word_i = w;
    word_valid_i = 1'b1;
    if (w[1]) begin
      exp_sym[2] = w[31:22];
      exp_sym[1] = w[21:12];
      exp_sym[0] = w[11:2];
    end else begin
      for (int k = 0; k < 3; k++) begin
        int nd;
        exp_sym[k] = enc_byte(w[8 + 8*k +: 8], exp_disp[k], nd);
        exp_disp[k] = nd;
      end
    end
    step();
    word_valid_i = 1'b0;
  endtask

  task automatic load_seamless(input logic [31:0] w, input string tag);
    while (cur_slot != 9) step();
    check_now(tag);
    load(w);
    watch(tag, 10);
  endtask

  initial begin
    #(4ns * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int k = 0; k < 3; k++) begin exp_sym[k] = '0; exp_disp[k] = 0; end
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    check("R1", {24'b0, pins_o}, 32'h40);
    check("R1", {31'b0, word_req_o}, 32'd0);
    rst_ni = 1'b1;
    cur_slot = 0;
    // R1 reset state, then R2 free-running clock pattern across wraps
    check("R1", {24'b0, pins_o}, 32'h40);
    watch("R2", 30);

    // R8 directed pixels: extremes, low byte must not matter
    load_seamless(32'h0000_0000, "R8");
    load_seamless(32'hFFFF_FF00, "R8");
    load_seamless(32'h10EF_80FD, "R8");
    load_seamless(32'h10EF_80F1, "R8");
    load_seamless(32'hAA55_0F00, "R8");

    // R7 literals, disparity continuity checked by the next pixel
    load_seamless({10'h354, 10'h0AB, 10'h2C3, 2'b10}, "R7");
    load_seamless({10'h3FF, 10'h000, 10'h155, 2'b11}, "R7");
    load_seamless(32'h5A5A_5A00, "R8");

    // R4 off-cadence loads
    while (cur_slot != 4) step();
    load({10'h1F0, 10'h00F, 10'h333, 2'b10});
    watch("R4", 10);
    while (cur_slot != 7) step();
    load(32'h1234_5600);
    watch("R4", 12);
    load(32'hC3C3_C300);
    watch("R4", 3);

    // R6 repeat with no new word
    watch("R6", 40);

    // R3 random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w = $urandom;
      if ($urandom_range(0, 2) == 0) w[1] = 1'b1; else w[1] = 1'b0;
      load_seamless(w, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule